// File: doc/BRIEF.md
# Performance Counter Read Port

This block serves software reads of hardware event counters by a 32-bit selector. It holds no counters itself. Two counter banks reach it as input arrays: a general-purpose bank and a fixed-function bank, each with its own implemented width above 32 bits. A one-cycle read strobe captures the selector. One clock later the block returns a 64-bit result with a one-cycle valid pulse.

The two top selector bits control the read. Bit 30 picks the bank. Bit 31 asks for a fast read, which returns only the low 32 counter bits with zeros above them. A normal read returns the counter cut to its bank's width. The low `IDX_BITS` selector bits number the counter inside the bank. Bits 29 down to `IDX_BITS` do not take part in decoding. A counter number that is not present in the chosen bank raises an error flag and returns zero.

Top module: `counter_read_port`

## Requirements
- R1: With selector bit 30 = 0, the read targets the general-purpose bank, at the counter numbered by selector bits [IDX_BITS-1:0].
- R2: With selector bit 30 = 1, the read targets the fixed bank, at the counter numbered by selector bits [IDX_BITS-1:0].
- R3: With selector bit 31 = 1 (fast read), result bits [31:0] equal counter bits [31:0] and result bits [63:32] are zero.
- R4: A normal read (bit 31 = 0) of the general-purpose bank returns counter bits [GP_WIDTH-1:0], and all result bits from GP_WIDTH upward are zero.
- R5: A normal read of the fixed bank returns counter bits [FIX_WIDTH-1:0], and all result bits from FIX_WIDTH upward are zero.
- R6: A counter number at or beyond the chosen bank's count (NUM_GP or NUM_FIX) sets the error output to 1 and returns zero data. A number within range clears the error output to 0.
- R7: Selector bits [29:IDX_BITS] have no effect on the result.
- R8: Valid is 1 exactly in the cycle after a strobe cycle. Data and error change only on that update and otherwise hold their values.
- R9: While reset is asserted, valid, data and error are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Read request, captures rdSel |
| rdSel | input | 32 | Read selector: bit 31 fast, bit 30 bank, low bits index |
| gpCnt | input | NUM_GP x 64 | General-purpose counter values |
| fixCnt | input | NUM_FIX x 64 | Fixed counter values |
| rdValid | output | 1 | One-cycle pulse marking a new result |
| rdData | output | 64 | Read result |
| rdErr | output | 1 | Counter number out of range for the read |

## Verification
The assertions assume that rdStrobe is a clean synchronous level. They also assume that the counter arrays are stable across the edge where a read is captured, because the result is sampled from them at that edge. The bench drives every input half a period away from the rising edge and holds the counter arrays constant for the whole run. This keeps each captured value fixed and known. The selector patterns cover both banks, both read modes, indices inside and outside each bank, and selectors with the ignored middle bits set.

// File: rtl/crp_pkg.sv
package crp_pkg;

  // Decoded read request handed from control to datapath.
  typedef struct packed {
    logic        load;       // capture a new result this cycle
    logic        fixedBank;  // 1: fixed bank, 0: general-purpose bank
    logic        fast;       // return low 32 bits only
    logic        rangeErr;   // index not present in chosen bank
    logic [29:0] idx;        // index with ignored bits cleared
  } ctrlStrobes_t;

  localparam int unsigned SEL_FAST_BIT = 31;
  localparam int unsigned SEL_BANK_BIT = 30;
  localparam int unsigned RESULT_W     = 64;

endpackage

// File: rtl/crp_ctrl.sv
module crp_ctrl #(
  parameter int unsigned NUM_GP   = 4,
  parameter int unsigned NUM_FIX  = 3,
  parameter int unsigned IDX_BITS = 8
) (
  input  logic                  rdStrobe,
  input  logic [31:0]           rdSel,
  output crp_pkg::ctrlStrobes_t ctl
);

  localparam logic [29:0] IDX_MASK = {30{1'b1}} >> (30 - IDX_BITS);
  localparam logic [29:0] GP_LIMIT  = 30'(NUM_GP);
  localparam logic [29:0] FIX_LIMIT = 30'(NUM_FIX);

  logic [29:0] idxField;
  logic        bankSel;

  always_comb begin
    idxField = rdSel[29:0] & IDX_MASK;
    bankSel  = rdSel[crp_pkg::SEL_BANK_BIT];
    ctl.load      = rdStrobe;
    ctl.fixedBank = bankSel;
    ctl.fast      = rdSel[crp_pkg::SEL_FAST_BIT];
    ctl.idx       = idxField;
    if (bankSel) ctl.rangeErr = (idxField >= FIX_LIMIT);
    else         ctl.rangeErr = (idxField >= GP_LIMIT);
  end

endmodule

// File: rtl/crp_dpath.sv
module crp_dpath #(
  parameter int unsigned NUM_GP    = 4,
  parameter int unsigned NUM_FIX   = 3,
  parameter int unsigned GP_WIDTH  = 48,
  parameter int unsigned FIX_WIDTH = 40
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  crp_pkg::ctrlStrobes_t      ctl,
  input  logic [NUM_GP-1:0][63:0]    gpCnt,
  input  logic [NUM_FIX-1:0][63:0]   fixCnt,
  output logic                       rdValid,
  output logic [63:0]                rdData,
  output logic                       rdErr
);

  localparam logic [63:0] GP_MASK  = {64{1'b1}} >> (64 - GP_WIDTH);
  localparam logic [63:0] FIX_MASK = {64{1'b1}} >> (64 - FIX_WIDTH);

  logic [63:0] gpPick, fixPick, bankPick, nextData;

  always_comb begin
    gpPick = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (ctl.idx == 30'(i)) gpPick = gpCnt[i] & GP_MASK;
  end

  always_comb begin
    fixPick = '0;
    for (int i = 0; i < NUM_FIX; i++)
      if (ctl.idx == 30'(i)) fixPick = fixCnt[i] & FIX_MASK;
  end

  always_comb begin
    bankPick = ctl.fixedBank ? fixPick : gpPick;
    if (ctl.fast) nextData = {32'b0, bankPick[31:0]};
    else          nextData = bankPick;
    if (ctl.rangeErr) nextData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdErr   <= 1'b0;
    end else begin
      rdValid <= ctl.load;
      if (ctl.load) begin
        rdData <= nextData;
        rdErr  <= ctl.rangeErr;
      end
    end
  end

  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> rdValid);
  a_r8_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> !rdValid);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(rdData) && $stable(rdErr)));
  a_r6_error_gives_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdErr) |-> (rdData == 64'd0));
  a_r3_fast_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.fast) |=> (rdData[63:32] == 32'd0));
  a_r4_gp_width: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.fixedBank) |=> ((rdData & ~GP_MASK) == 64'd0));
  a_r5_fix_width: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.fixedBank) |=> ((rdData & ~FIX_MASK) == 64'd0));

endmodule

// File: rtl/counter_read_port.sv
module counter_read_port #(
  parameter int unsigned NUM_GP    = 4,
  parameter int unsigned NUM_FIX   = 3,
  parameter int unsigned GP_WIDTH  = 48,
  parameter int unsigned FIX_WIDTH = 40,
  parameter int unsigned IDX_BITS  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdStrobe,
  input  logic [31:0]              rdSel,
  input  logic [NUM_GP-1:0][63:0]  gpCnt,
  input  logic [NUM_FIX-1:0][63:0] fixCnt,
  output logic                     rdValid,
  output logic [63:0]              rdData,
  output logic                     rdErr
);

  crp_pkg::ctrlStrobes_t ctl;

  crp_ctrl #(
    .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .IDX_BITS(IDX_BITS)
  ) u_ctrl (
    .rdStrobe(rdStrobe), .rdSel(rdSel), .ctl(ctl)
  );

  crp_dpath #(
    .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX),
    .GP_WIDTH(GP_WIDTH), .FIX_WIDTH(FIX_WIDTH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .gpCnt(gpCnt), .fixCnt(fixCnt),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr)
  );

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!rdValid && rdData == 64'd0 && !rdErr));

endmodule

// File: tb/sim_counter_read_port.sv
module sim_counter_read_port;

  localparam int NG = 4, NF = 3, GW = 48, FW = 40;
  localparam int NV = 12;

  localparam logic [31:0] SELS [NV] = '{
    32'h0000_0000, 32'h0000_0003, 32'h4000_0000, 32'h4000_0002,
    32'h8000_0001, 32'hC000_0001, 32'h0000_0004, 32'h4000_0003,
    32'hC000_00FF, 32'h3FFF_FF02, 32'h7FFF_FF01, 32'h8000_0100 };
  localparam bit EXPERR [NV] = '{0,0,0,0, 0,0,1,1, 1,0,0,0};
  localparam string TAGS [NV] = '{
    "R1 R4", "R1 R4", "R2 R5", "R2 R5", "R3", "R3 R2", "R6", "R6",
    "R6", "R7", "R7", "R7 R3" };

  logic clk = 0, rstN = 0, rdStrobe = 0;
  logic [31:0] rdSel = '0;
  logic [NG-1:0][63:0] gpCnt;
  logic [NF-1:0][63:0] fixCnt;
  logic rdValid, rdErr;
  logic [63:0] rdData;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  counter_read_port u0 (.clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSel(rdSel),
    .gpCnt(gpCnt), .fixCnt(fixCnt), .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr));

  function automatic logic [63:0] gpVal(int i);
    return 64'hFEDC_BA98_7654_3210 + 64'(i) * 64'h0101_0101_0101_0101;
  endfunction
  function automatic logic [63:0] fixVal(int i);
    return 64'h9F34_5678_9ABC_DEF0 ^ (64'(i) * 64'h1111_0000_0000_1111);
  endfunction

  function automatic logic [63:0] model(logic [31:0] s);
    int idx = int'(s[7:0]);
    logic [63:0] v;
    if (s[30]) begin
      if (idx >= NF) return 64'd0;
      v = fixVal(idx) & ((64'd1 << FW) - 1);
    end else begin
      if (idx >= NG) return 64'd0;
      v = gpVal(idx) & ((64'd1 << GW) - 1);
    end
    if (s[31]) v = {32'd0, v[31:0]};
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doRead(logic [31:0] s);
    @(negedge clk); rdSel = s; rdStrobe = 1;
    @(negedge clk); rdStrobe = 0; rdSel = 32'hFFFF_FFFF;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NG; i++) gpCnt[i] = gpVal(i);
    for (int i = 0; i < NF; i++) fixCnt[i] = fixVal(i);
    rdSel = 32'h0000_0001; rdStrobe = 1;
    repeat (3) @(negedge clk);
    check("R9 valid", 64'(rdValid), 64'd0);
    check("R9 data", rdData, 64'd0);
    check("R9 err", 64'(rdErr), 64'd0);
    rdStrobe = 0;
    @(negedge clk); rstN = 1;

    for (int k = 0; k < NV; k++) begin
      doRead(SELS[k]);
      check({TAGS[k], " valid"}, 64'(rdValid), 64'd1);
      check({TAGS[k], " data"}, rdData, model(SELS[k]));
      check({TAGS[k], " err"}, 64'(rdErr), 64'(EXPERR[k]));
    end

    // R8: one-cycle pulse, then hold
    doRead(32'h4000_0001);
    @(negedge clk);
    check("R8 pulse ends", 64'(rdValid), 64'd0);
    check("R8 data holds", rdData, model(32'h4000_0001));
    repeat (3) @(negedge clk);
    check("R8 err holds", 64'(rdErr), 64'd0);

    // R6 then in-range read clears error
    doRead(32'h0000_0080);
    check("R6 err set", 64'(rdErr), 64'd1);
    @(negedge clk);
    check("R8 err held", 64'(rdErr), 64'd1);
    doRead(32'h0000_0002);
    check("R6 err cleared", 64'(rdErr), 64'd0);
    check("R1 gp2", rdData, gpVal(2) & ((64'd1 << GW) - 1));

    // back-to-back strobes
    @(negedge clk); rdSel = 32'h0000_0001; rdStrobe = 1;
    @(negedge clk); rdSel = 32'h8000_0003;
    check("R8 first", rdData, model(32'h0000_0001));
    @(negedge clk); rdStrobe = 0;
    check("R8 second valid", 64'(rdValid), 64'd1);
    check("R3 second", rdData, model(32'h8000_0003));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule